// File: doc/BRIEF.md
# Power-Up and Master-Reset Initialization Sequencer

This block decides when a chip's user outputs may drive and when its user registers may leave their initial state. A digital power-good input marks valid supply; while it is low everything is held off at once, without waiting for a clock. Once power is good, a fixed-length initialization period runs. During that period the outputs are held in high impedance and the register-init line is asserted.

An active-low master-reset pin works alongside power-good. The pin is synchronized and then filtered by a run-length counter, so short pulses never reach the sequencer. A qualified falling edge on the pin at any time after power-up disables the outputs on that same clock and starts a fresh, full initialization. The outputs are released only when two conditions hold together: the initialization period has elapsed and the filtered pin is high. If the pin is still low when the period ends, the sequencer parks in a hold state. In that state registers are released but outputs stay disabled until the pin goes high.

The sequencer has four states: off, init, hold and run. The busy flag is high in every state except run. The period length, synchronizer depth and minimum pulse width are parameters counted in clock cycles.

Top module: `boot_sequencer`

## Requirements
- R1: While pwrGood is low, outEnable is 0, regInit is 1 and busy is 1, taking effect asynchronously without waiting for a clock edge.
- R2: The first rising clock edge after pwrGood rises enters the init state, which lasts exactly INIT_CYCLES cycles with regInit at 1 and outEnable at 0 throughout.
- R3: With the reset pin held high, outEnable rises at the (INIT_CYCLES+1)-th rising edge after pwrGood rose, and regInit falls at the same edge.
- R4: If the filtered reset pin is low when the init period ends, the block holds with outEnable 0, regInit 0 and busy 1. It enters run at the first edge after the filtered pin is seen high, which is SYNC_STAGES+MIN_PULSE+1 edges after the raw pin rises.
- R5: Pin levels (low or high) that last fewer than MIN_PULSE consecutive synchronized cycles are ignored and do not change any output.
- R6: When the reset pin goes low for at least MIN_PULSE cycles, outEnable drops and regInit rises at the (SYNC_STAGES+MIN_PULSE)-th rising edge after the pin fell, and a full INIT_CYCLES init period starts.
- R7: A qualified falling edge of the reset pin during the init period restarts the period from its full length.
- R8: busy is always the inverse of outEnable, and outEnable and regInit are never high together.
- R9: If the reset pin was low at power-up but is qualified high before the init period ends, the block enters run directly when the period ends, with no extra hold cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwrGood | input | 1 | Supply valid; low acts as an asynchronous reset of the whole block |
| rstPinN | input | 1 | Active-low master-reset pin, asynchronous to clk |
| outEnable | output | 1 | High lets user outputs drive; low holds them tri-stated |
| regInit | output | 1 | High forces user registers to their initial state |
| busy | output | 1 | High in every state except run |

## Verification
Several properties hold on every cycle and are checked continuously. The outputs take their off values whenever power is bad. busy and outEnable are always complementary, and outputs are never enabled while registers are in init. Outputs are enabled only while the filtered pin is high. Every qualified falling edge is followed by disabled outputs, and the init phase is left only when the period counter reports completion. Other behaviour needs a time window or a history of stimulus, and only the bench scenarios show it. This covers the exact release cycle after power-up, glitch rejection of both polarities, the restart of a period that is already running, the hold-then-release path, and the direct release when the pin rises during initialization.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_RUN  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerLoad;
    logic timerRun;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pinHigh;
    logic pinFallNow;
    logic initDone;
  } dpStatus_t;

endpackage

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int INIT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        pwrGood,
  input  logic        rstPinN,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int DB_W = (MIN_PULSE > 2) ? $clog2(MIN_PULSE) : 1;
  localparam int TM_W = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(MIN_PULSE - 1);
  localparam logic [TM_W-1:0] TM_LOAD = TM_W'(INIT_CYCLES - 1);

  // synchronizer chain
  logic [SYNC_STAGES-1:0] syncReg;
  logic syncOut;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge pwrGood) begin
        if (!pwrGood) syncReg <= '0;
        else          syncReg <= rstPinN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge pwrGood) begin
        if (!pwrGood) syncReg <= '0;
        else          syncReg <= {syncReg[SYNC_STAGES-2:0], rstPinN};
      end
    end
  endgenerate

  assign syncOut = syncReg[SYNC_STAGES-1];

  // run-length filter: the level must differ for MIN_PULSE cycles
  logic [DB_W-1:0] dbCnt;
  logic pinFilt;
  logic differ;
  logic flipNow;

  assign differ  = syncOut ^ pinFilt;
  assign flipNow = differ && (dbCnt == DB_LAST);

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      dbCnt   <= '0;
      pinFilt <= 1'b0;
    end else if (!differ) begin
      dbCnt   <= '0;
    end else if (flipNow) begin
      dbCnt   <= '0;
      pinFilt <= syncOut;
    end else begin
      dbCnt   <= dbCnt + 1'b1;
    end
  end

  // init period down-counter
  logic [TM_W-1:0] timerCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)                               timerCnt <= '0;
    else if (strobe.timerLoad)                  timerCnt <= TM_LOAD;
    else if (strobe.timerRun && timerCnt != '0) timerCnt <= timerCnt - 1'b1;
  end

  assign status.pinHigh    = pinFilt;
  assign status.pinFallNow = flipNow && pinFilt;
  assign status.initDone   = (timerCnt == '0);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic        clk,
  input  logic        pwrGood,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        outEnable,
  output logic        regInit,
  output logic        busy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) state <= ST_OFF;
    else          state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF:  stateNext = ST_INIT;
      ST_INIT: begin
        if (status.pinFallNow)    stateNext = ST_INIT;
        else if (status.initDone) stateNext = status.pinHigh ? ST_RUN : ST_HOLD;
      end
      ST_HOLD: if (status.pinHigh)    stateNext = ST_RUN;
      ST_RUN:  if (status.pinFallNow) stateNext = ST_INIT;
      default: stateNext = ST_OFF;
    endcase
  end

  always_comb begin
    strobe.timerLoad = (state == ST_OFF) || status.pinFallNow;
    strobe.timerRun  = (state == ST_INIT);
  end

  assign outEnable = (state == ST_RUN);
  assign regInit   = (state == ST_OFF) || (state == ST_INIT);
  assign busy      = (state != ST_RUN);

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic rstPinN,
  output logic outEnable,
  output logic regInit,
  output logic busy
);

  ctrlStrobe_t ctrlStb;
  dpStatus_t   dpStat;

  boot_seq_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_PULSE   (MIN_PULSE),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_dp (
    .clk     (clk),
    .pwrGood (pwrGood),
    .rstPinN (rstPinN),
    .strobe  (ctrlStb),
    .status  (dpStat)
  );

  boot_seq_ctrl u_ctrl (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .status    (dpStat),
    .strobe    (ctrlStb),
    .outEnable (outEnable),
    .regInit   (regInit),
    .busy      (busy)
  );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic clk,
  input logic pwrGood,
  input logic outEnable,
  input logic regInit,
  input logic busy,
  input logic pinHigh,
  input logic pinFallNow,
  input logic initDone
);

  // R1
  always @(negedge clk) begin
    if (pwrGood == 1'b0) begin
      r1_off_chk: assert (!outEnable && regInit && busy)
        else $error("R1 outputs not off while power is bad");
    end
  end

  // R2
  r2_init_exit_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    $fell(regInit) |-> $past(initDone))
    else $error("R2 init left before period done");

  // R4
  r4_pin_release_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    outEnable |-> pinHigh)
    else $error("R4 outputs enabled with pin low");

  // R6
  r6_fall_off_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    pinFallNow |=> (!outEnable && regInit))
    else $error("R6 qualified fall did not restart init");

  // R8
  r8_busy_inv_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    busy == !outEnable)
    else $error("R8 busy not inverse of outEnable");

  // R8
  r8_excl_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    !(outEnable && regInit))
    else $error("R8 outputs enabled during register init");

endmodule

bind boot_sequencer boot_seq_chk u_chk (
  .clk        (clk),
  .pwrGood    (pwrGood),
  .outEnable  (outEnable),
  .regInit    (regInit),
  .busy       (busy),
  .pinHigh    (dpStat.pinHigh),
  .pinFallNow (dpStat.pinFallNow),
  .initDone   (dpStat.initDone)
);

// File: tb/sim_boot_sequencer.sv
module sim_boot_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC  = 2;
  localparam int MINP  = 4;
  localparam int INITC = 16;

  logic clk = 1'b0;
  logic pwrGood;
  logic rstPinN;
  logic outEnable, regInit, busy;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";
  bit finished = 0;

  boot_sequencer #(
    .SYNC_STAGES (SYNC),
    .MIN_PULSE   (MINP),
    .INIT_CYCLES (INITC)
  ) u0 (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .rstPinN   (rstPinN),
    .outEnable (outEnable),
    .regInit   (regInit),
    .busy      (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: 0 off, 1 init, 2 hold, 3 run
  int mState;
  bit mFilt;
  int mRun;
  int mTimer;
  bit pinHist[$];

  function automatic void modelReset();
    mState = 0;
    mFilt  = 0;
    mRun   = 0;
    mTimer = 0;
    pinHist = {};
    for (int i = 0; i < SYNC; i++) pinHist.push_back(1'b0);
  endfunction

  initial modelReset();

  always @(posedge clk) begin : model
    bit seen, fall, oldFilt, done;
    if (!pwrGood) begin
      modelReset();
    end else begin
      seen    = pinHist[0];
      oldFilt = mFilt;
      done    = (mTimer == 0);
      fall    = 0;
      if (seen != mFilt) begin
        if (mRun == MINP - 1) begin
          fall  = mFilt;
          mFilt = seen;
          mRun  = 0;
        end else begin
          mRun++;
        end
      end else begin
        mRun = 0;
      end
      void'(pinHist.pop_front());
      pinHist.push_back(rstPinN);
      case (mState)
        0: begin mState = 1; mTimer = INITC - 1; end
        1: begin
          if (fall)      mTimer = INITC - 1;
          else if (done) mState = oldFilt ? 3 : 2;
          else           mTimer--;
        end
        2: if (oldFilt) mState = 3;
        default: if (fall) begin mState = 1; mTimer = INITC - 1; end
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit expOe, expInit, expBusy;
    if (!finished) begin
      expOe   = pwrGood && (mState == 3);
      expInit = !pwrGood || (mState <= 1);
      expBusy = !expOe;
      vectors++;
      if (outEnable !== expOe || regInit !== expInit || busy !== expBusy) begin
        miscompares++;
        $display("FAIL %s model: oe/init/busy actual %b%b%b expected %b%b%b at %0t",
                 curReq, outEnable, regInit, busy, expOe, expInit, expBusy, $time);
      end
    end
  end

  task automatic check(input bit actual, input bit expected, input string req, input string what);
    vectors++;
    if (actual !== expected) begin
      miscompares++;
      $display("FAIL %s %s actual %b expected %b at %0t", req, what, actual, expected, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired in %s", curReq);
    finish();
  end

  initial begin
    pwrGood = 1'b1;
    rstPinN = 1'b1;
    #3 pwrGood = 1'b0;
    tick(3);
    // R1 reset state
    check(outEnable, 1'b0, "R1", "outEnable");
    check(regInit,   1'b1, "R1", "regInit");
    check(busy,      1'b1, "R1", "busy");

    // R2 / R3 power-up with pin high
    curReq = "R2";
    pwrGood = 1'b1;
    tick(INITC);
    check(outEnable, 1'b0, "R2", "outEnable last init cycle");
    check(regInit,   1'b1, "R2", "regInit last init cycle");
    curReq = "R3";
    tick(1);
    check(outEnable, 1'b1, "R3", "outEnable after period");
    check(regInit,   1'b0, "R3", "regInit after period");
    check(busy,      1'b0, "R8", "busy in run");

    // R5 short low glitch ignored
    curReq = "R5";
    rstPinN = 1'b0;
    tick(3);
    rstPinN = 1'b1;
    tick(12);
    check(outEnable, 1'b1, "R5", "outEnable after short low pulse");

    // R6 qualified low pulse restarts init
    curReq = "R6";
    rstPinN = 1'b0;
    tick(SYNC + MINP - 1);
    check(outEnable, 1'b1, "R6", "outEnable one edge before fall");
    tick(1);
    check(outEnable, 1'b0, "R6", "outEnable at fall edge");
    check(regInit,   1'b1, "R6", "regInit at fall edge");

    // R4 hold state while pin stays low
    curReq = "R4";
    tick(INITC + 4);
    check(outEnable, 1'b0, "R4", "outEnable in hold");
    check(regInit,   1'b0, "R4", "regInit in hold");
    check(busy,      1'b1, "R4", "busy in hold");

    // R5 short high glitch ignored in hold
    curReq = "R5";
    rstPinN = 1'b1;
    tick(3);
    rstPinN = 1'b0;
    tick(10);
    check(busy, 1'b1, "R5", "busy after short high pulse");

    // R4 release from hold
    curReq = "R4";
    rstPinN = 1'b1;
    tick(SYNC + MINP);
    check(outEnable, 1'b0, "R4", "outEnable before release edge");
    tick(1);
    check(outEnable, 1'b1, "R4", "outEnable after release");

    // R7 fall during init restarts the period
    curReq = "R7";
    rstPinN = 1'b0;
    tick(8);
    rstPinN = 1'b1;
    tick(6);
    rstPinN = 1'b0;
    tick(6);
    rstPinN = 1'b1;
    tick(INITC - 1);
    check(regInit,   1'b1, "R7", "regInit still in restarted init");
    tick(1);
    check(outEnable, 1'b1, "R7", "outEnable after restarted period");

    // R1 asynchronous power loss, then R9 pin low at power-up
    curReq = "R1";
    pwrGood = 1'b0;
    #1;
    check(outEnable, 1'b0, "R1", "outEnable right after power loss");
    check(regInit,   1'b1, "R1", "regInit right after power loss");
    curReq = "R9";
    tick(2);
    rstPinN = 1'b0;
    tick(2);
    pwrGood = 1'b1;
    tick(5);
    rstPinN = 1'b1;
    tick(11);
    check(outEnable, 1'b0, "R9", "outEnable last init cycle");
    tick(1);
    check(outEnable, 1'b1, "R9", "outEnable at period end");
    check(busy,      1'b0, "R8", "busy after direct release");

    tick(4);
    finish();
  end

endmodule